// File: doc/BRIEF.md
# Masked Bus Address Watchpoint Unit

This block observes the address phase of one AHB port belonging to a DMA controller. It never drives that bus. Two debugger-owned registers set what it looks for: a watch address and a watch mask. A mask bit of 1 removes the corresponding address bit from the comparison, so one watch value can cover a single address, an aligned range or a scattered set of addresses.

When debug is enabled and a valid transfer presents a matching address, the block raises a debug request toward the processor. In the same cycle it raises a freeze toward the observed port's state machine. Both outputs hold until debug is disabled.

The two registers belong to the debug domain. Only the active-low test reset clears them, and only an access flagged as coming from a debugger can change them.

Top module: `wpu_top`

## Requirements
- R1: The watch address register reads back as 0 after test reset and is read at register offset 0x184. Reads are combinational on `reg_addr`.
- R2: The watch mask register reads back as 0 after test reset and is read at offset 0x188. Any other offset reads as 0.
- R3: A write with `reg_wr`=1 and `reg_dbg_acc`=1 to either offset updates that register at the clock edge. The new value reads back after that edge.
- R4: A write with `reg_dbg_acc`=0 leaves both registers unchanged.
- R5: An address hits when every bit position whose mask bit is 0 has an address bit equal to the watch bit. Positions whose mask bit is 1 are not compared.
- R6: An address is compared only in a valid phase: `hready`=1 and `htrans` equal to 2'b10 (NONSEQ) or 2'b11 (SEQ). IDLE (2'b00), BUSY (2'b01) and phases with `hready`=0 never hit.
- R7: `dbg_req` and `port_freeze` rise together at the clock edge that ends the matching phase. They do not rise before that edge.
- R8: No hit is recorded while `dbg_en`=0, and raising `dbg_en` later does not recall an earlier match.
- R9: Once set, `dbg_req` and `port_freeze` stay at 1 while `dbg_en` stays 1. They clear at the first clock edge that sees `dbg_en`=0.
- R10: `trst_n`=0 clears both registers and both outputs at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| trst_n | input | 1 | Active-low asynchronous test reset |
| dbg_en | input | 1 | Debug enable for watchpoint hits |
| reg_addr | input | REG_AW | Register offset for reads and writes |
| reg_wr | input | 1 | Register write strobe |
| reg_dbg_acc | input | 1 | Access originates from the debugger |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data |
| htrans | input | 2 | Observed AHB transfer type |
| hready | input | 1 | Observed AHB ready |
| haddr | input | ADDR_W | Observed AHB address |
| dbg_req | output | 1 | Debug request to the processor |
| port_freeze | output | 1 | Freeze of the observed port's state machine |

## Verification
The bench builds the unit with an 8-bit address and a 4-bit compare chunk. The address space then has only 256 values, and the chunked comparison path is selected rather than the flat one. Every address is swept against an exact watch value, a 16-address aligned range, a scattered mask and a fully masked watch. Each expected hit is computed arithmetically from the masking rule.

// File: rtl/wpu_pkg.sv
package wpu_pkg;

   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } htrans_e;

   // A transfer is sampled only when it is active and the bus is ready.
   function automatic logic phase_valid(input logic [1:0] tr, input logic rdy);
      return rdy && (tr == TR_NONSEQ || tr == TR_SEQ);
   endfunction

endpackage

// File: rtl/wpu_regs.sv
module wpu_regs #(
   parameter int unsigned         DATA_W = 32,
   parameter int unsigned         REG_AW = 12,
   parameter logic [REG_AW-1:0]   WP_OFS = 12'h184,
   parameter logic [REG_AW-1:0]   WM_OFS = 12'h188
) (
   input  logic              clk,
   input  logic              trst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_dbg_acc,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] wp_q,
   output logic [DATA_W-1:0] wm_q
);

   if (WP_OFS == WM_OFS) begin : g_ofs_clash
      $error("wpu_regs: watch and mask offsets must differ");
   end

   logic wr_ok;
   logic wp_sel, wm_sel;

   assign wr_ok  = reg_wr && reg_dbg_acc;
   assign wp_sel = (reg_addr == WP_OFS);
   assign wm_sel = (reg_addr == WM_OFS);

   always_ff @(posedge clk or negedge trst_n) begin
      if (!trst_n) begin
         wp_q <= '0;
      end else if (wr_ok && wp_sel) begin
         wp_q <= reg_wdata;
      end
   end

   always_ff @(posedge clk or negedge trst_n) begin
      if (!trst_n) begin
         wm_q <= '0;
      end else if (wr_ok && wm_sel) begin
         wm_q <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (wp_sel) reg_rdata = wp_q;
      if (wm_sel) reg_rdata = wm_q;
   end

   // R4: a write without the debugger qualifier changes neither register
   a_r4_nondebug_write_ignored: assert property (@(posedge clk) disable iff (!trst_n)
      !reg_dbg_acc |=> ($stable(wp_q) && $stable(wm_q)));

   // R3: a qualified write to the watch offset is visible after the edge
   a_r3_wp_write_lands: assert property (@(posedge clk) disable iff (!trst_n)
      (reg_wr && reg_dbg_acc && reg_addr == WP_OFS) |=> (wp_q == $past(reg_wdata)));

endmodule

// File: rtl/wpu_match.sv
module wpu_match
   import wpu_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned CHUNK_W = 8
) (
   input  logic [ADDR_W-1:0] haddr,
   input  logic [1:0]        htrans,
   input  logic              hready,
   input  logic [ADDR_W-1:0] wp,
   input  logic [ADDR_W-1:0] wm,
   output logic              hit_now
);

   localparam int unsigned N_CHUNK = (ADDR_W + CHUNK_W - 1) / CHUNK_W;

   if (CHUNK_W == 0) begin : g_bad_chunk
      $error("wpu_match: CHUNK_W must be nonzero");
   end

   logic [ADDR_W-1:0] diff;
   logic              any_miss;

   // Bits that differ and are not masked out.
   assign diff = (haddr ^ wp) & ~wm;

   if (CHUNK_W >= ADDR_W) begin : g_flat
      assign any_miss = |diff;
   end else begin : g_chunked
      logic [N_CHUNK-1:0] miss;
      for (genvar i = 0; i < N_CHUNK; i++) begin : g_chunk
         localparam int unsigned LO = i * CHUNK_W;
         localparam int unsigned HI = ((i + 1) * CHUNK_W > ADDR_W) ?
                                      ADDR_W - 1 : (i + 1) * CHUNK_W - 1;
         assign miss[i] = |diff[HI:LO];
      end
      assign any_miss = |miss;
   end

   assign hit_now = phase_valid(htrans, hready) && !any_miss;

endmodule

// File: rtl/wpu_hold.sv
module wpu_hold (
   input  logic clk,
   input  logic trst_n,
   input  logic dbg_en,
   input  logic hit_now,
   output logic dbg_req,
   output logic port_freeze
);

   always_ff @(posedge clk or negedge trst_n) begin
      if (!trst_n) begin
         dbg_req <= 1'b0;
      end else if (!dbg_en) begin
         dbg_req <= 1'b0;
      end else if (hit_now) begin
         dbg_req <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge trst_n) begin
      if (!trst_n) begin
         port_freeze <= 1'b0;
      end else if (!dbg_en) begin
         port_freeze <= 1'b0;
      end else if (hit_now) begin
         port_freeze <= 1'b1;
      end
   end

   // R9: a held request survives while debug stays enabled
   a_r9_sticky: assert property (@(posedge clk) disable iff (!trst_n)
      (dbg_req && dbg_en) |=> dbg_req);

   // R9: disabling debug clears the request at the next edge
   a_r9_clear_on_disable: assert property (@(posedge clk) disable iff (!trst_n)
      !dbg_en |=> (!dbg_req && !port_freeze));

   // R7: both outputs move together
   a_r7_outputs_agree: assert property (@(posedge clk) disable iff (!trst_n)
      dbg_req == port_freeze);

endmodule

// File: rtl/wpu_top.sv
module wpu_top
   import wpu_pkg::*;
#(
   parameter int unsigned        ADDR_W  = 32,
   parameter int unsigned        CHUNK_W = 8,
   parameter int unsigned        REG_AW  = 12,
   parameter logic [REG_AW-1:0]  WP_OFS  = 12'h184,
   parameter logic [REG_AW-1:0]  WM_OFS  = 12'h188
) (
   input  logic              clk,
   input  logic              trst_n,
   input  logic              dbg_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_dbg_acc,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic [1:0]        htrans,
   input  logic              hready,
   input  logic [ADDR_W-1:0] haddr,
   output logic              dbg_req,
   output logic              port_freeze
);

   if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_width
      $error("wpu_top: ADDR_W must be 1..64");
   end

   logic [ADDR_W-1:0] wp_q, wm_q;
   logic              hit_now;

   wpu_regs #(
      .DATA_W (ADDR_W),
      .REG_AW (REG_AW),
      .WP_OFS (WP_OFS),
      .WM_OFS (WM_OFS)
   ) u_regs (
      .clk         (clk),
      .trst_n      (trst_n),
      .reg_addr    (reg_addr),
      .reg_wr      (reg_wr),
      .reg_dbg_acc (reg_dbg_acc),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .wp_q        (wp_q),
      .wm_q        (wm_q)
   );

   wpu_match #(
      .ADDR_W  (ADDR_W),
      .CHUNK_W (CHUNK_W)
   ) u_match (
      .haddr   (haddr),
      .htrans  (htrans),
      .hready  (hready),
      .wp      (wp_q),
      .wm      (wm_q),
      .hit_now (hit_now)
   );

   wpu_hold u_hold (
      .clk         (clk),
      .trst_n      (trst_n),
      .dbg_en      (dbg_en),
      .hit_now     (hit_now),
      .dbg_req     (dbg_req),
      .port_freeze (port_freeze)
   );

   // R6: a new request only follows a valid, ready transfer
   a_r6_valid_phase_only: assert property (@(posedge clk) disable iff (!trst_n)
      $rose(dbg_req) |-> ($past(hready) && $past(htrans[1])));

   // R5: a new request only follows an address that met the masked compare
   a_r5_masked_match: assert property (@(posedge clk) disable iff (!trst_n)
      $rose(dbg_req) |-> ($past((haddr ^ wp_q) & ~wm_q) == '0));

   // R8: a new request only follows a cycle with debug enabled
   a_r8_needs_enable: assert property (@(posedge clk) disable iff (!trst_n)
      $rose(dbg_req) |-> $past(dbg_en));

endmodule

// File: tb/wpu_top_tb_top.sv
module wpu_top_tb_top;

   localparam int unsigned AW = 8;
   localparam int unsigned RW = 12;
   localparam logic [RW-1:0] OFS_WP = 12'h184;
   localparam logic [RW-1:0] OFS_WM = 12'h188;

   logic          clk = 1'b0;
   logic          trst_n = 1'b0;
   logic          dbg_en = 1'b0;
   logic [RW-1:0] reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic          reg_dbg_acc = 1'b0;
   logic [AW-1:0] reg_wdata = '0;
   logic [AW-1:0] reg_rdata;
   logic [1:0]    htrans = 2'b00;
   logic          hready = 1'b1;
   logic [AW-1:0] haddr = '0;
   logic          dbg_req, port_freeze;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   wpu_top #(
      .ADDR_W (AW), .CHUNK_W (4), .REG_AW (RW), .WP_OFS (OFS_WP), .WM_OFS (OFS_WM)
   ) dut_i (
      .clk (clk), .trst_n (trst_n), .dbg_en (dbg_en),
      .reg_addr (reg_addr), .reg_wr (reg_wr), .reg_dbg_acc (reg_dbg_acc),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .htrans (htrans), .hready (hready), .haddr (haddr),
      .dbg_req (dbg_req), .port_freeze (port_freeze)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [RW-1:0] a, input logic [AW-1:0] d, input logic dbg);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_dbg_acc = dbg;
      @(negedge clk);
      reg_wr = 1'b0; reg_dbg_acc = 1'b0;
   endtask

   task automatic rd_reg(input logic [RW-1:0] a, output logic [AW-1:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // Present one address phase; return at the negedge after its closing edge.
   task automatic phase(input logic [AW-1:0] a, input logic [1:0] tr, input logic rdy);
      @(negedge clk);
      haddr = a; htrans = tr; hready = rdy;
      @(negedge clk);
      htrans = 2'b00; hready = 1'b1;
   endtask

   task automatic clear_hit();
      dbg_en = 1'b0;
      @(negedge clk);
      dbg_en = 1'b1;
   endtask

   logic [AW-1:0] rv;
   logic [AW-1:0] wpv [4] = '{8'hA5, 8'h40, 8'h81, 8'h3C};
   logic [AW-1:0] wmv [4] = '{8'h00, 8'h0F, 8'h7E, 8'hFF};

   initial begin
      repeat (3) @(negedge clk);
      // R10 / R1 / R2: state during and after test reset
      chk("R10", {dbg_req, port_freeze}, 2'b00);
      trst_n = 1'b1;
      @(negedge clk);
      rd_reg(OFS_WP, rv); chk("R1", rv, 8'h00);
      rd_reg(OFS_WM, rv); chk("R2", rv, 8'h00);

      // R3: debugger writes land
      wr_reg(OFS_WP, 8'h5A, 1'b1);
      rd_reg(OFS_WP, rv); chk("R3", rv, 8'h5A);
      wr_reg(OFS_WM, 8'hC3, 1'b1);
      rd_reg(OFS_WM, rv); chk("R3", rv, 8'hC3);
      // R4: non-debug writes ignored
      wr_reg(OFS_WP, 8'h11, 1'b0);
      wr_reg(OFS_WM, 8'h22, 1'b0);
      rd_reg(OFS_WP, rv); chk("R4", rv, 8'h5A);
      rd_reg(OFS_WM, rv); chk("R4", rv, 8'hC3);
      // R2: unmapped offset reads zero
      rd_reg(12'h18C, rv); chk("R2", rv, 8'h00);

      dbg_en = 1'b1;
      // R5: exhaustive sweep over each watch/mask pair
      for (int m = 0; m < 4; m++) begin
         wr_reg(OFS_WP, wpv[m], 1'b1);
         wr_reg(OFS_WM, wmv[m], 1'b1);
         for (int a = 0; a < 256; a++) begin
            logic e;
            e = (((a[AW-1:0] ^ wpv[m]) & ~wmv[m]) == '0);
            phase(a[AW-1:0], a[0] ? 2'b11 : 2'b10, 1'b1);
            chk("R5", {dbg_req, port_freeze}, {e, e});
            clear_hit();
         end
      end

      // Exact watch at 0x66 for the remaining checks
      wr_reg(OFS_WP, 8'h66, 1'b1);
      wr_reg(OFS_WM, 8'h00, 1'b1);
      // R6: IDLE, BUSY and not-ready phases never hit
      phase(8'h66, 2'b00, 1'b1); chk("R6", {dbg_req, port_freeze}, 2'b00);
      phase(8'h66, 2'b01, 1'b1); chk("R6", {dbg_req, port_freeze}, 2'b00);
      phase(8'h66, 2'b10, 1'b0); chk("R6", {dbg_req, port_freeze}, 2'b00);
      phase(8'h66, 2'b11, 1'b0); chk("R6", {dbg_req, port_freeze}, 2'b00);

      // R7: nothing before the edge, both outputs after it
      @(negedge clk);
      haddr = 8'h66; htrans = 2'b10; hready = 1'b1;
      #1 chk("R7", {dbg_req, port_freeze}, 2'b00);
      @(negedge clk);
      htrans = 2'b00;
      chk("R7", {dbg_req, port_freeze}, 2'b11);

      // R9: holds while enabled, clears at the edge after disable
      repeat (4) @(negedge clk);
      chk("R9", {dbg_req, port_freeze}, 2'b11);
      dbg_en = 1'b0;
      #1 chk("R9", {dbg_req, port_freeze}, 2'b11);
      @(negedge clk);
      chk("R9", {dbg_req, port_freeze}, 2'b00);

      // R8: no hit while disabled, no recall on enable
      phase(8'h66, 2'b10, 1'b1); chk("R8", {dbg_req, port_freeze}, 2'b00);
      dbg_en = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8", {dbg_req, port_freeze}, 2'b00);

      // R10: asynchronous test reset clears outputs and registers
      phase(8'h66, 2'b11, 1'b1); chk("R10", {dbg_req, port_freeze}, 2'b11);
      #3 trst_n = 1'b0;
      #1 chk("R10", {dbg_req, port_freeze}, 2'b00);
      rd_reg(OFS_WP, rv); chk("R10", rv, 8'h00);
      rd_reg(OFS_WM, rv); chk("R10", rv, 8'h00);
      @(negedge clk);
      trst_n = 1'b1;

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule